// File: doc/BRIEF.md
# Timer Count-Clock Source Selector

This block decides when a 16-bit up-counter advances. It works in one of two ways. In the first, a free-running divider of the system clock supplies a count pulse once every 2^n cycles, where n is a 4-bit select code. In the second, each rising edge on an asynchronous event pin is counted, so the counter acts as an event counter. The block drives a one-cycle count-enable strobe and the counter value that the strobe advances.

A run input starts and halts counting. Software sets the source bit and the divider code only while the block is halted. The block captures both on every halted cycle and freezes them while running. The block carries no data stream, so all of its pins are plain control and status signals with no handshake.

Top module: `tcs_count_src`

## Requirements
- R1: A synchronous reset (`rst_i` high) clears the counter to 0 and sets the configuration to internal source with select code 0 (divide-by-1). Inputs presented while reset is high are not captured if `run_i` is high on the first edge after reset.
- R2: With `src_sel_i`=0 and select code n in 0..14, `cnt_en_o` is high on every 2^n-th cycle of a run. The first pulse comes on the 2^n-th running cycle after start, so after C running cycles the counter holds floor(C/2^n).
- R3: Select code 15 (all ones) is reserved and produces no count-enable pulse.
- R4: With `src_sel_i`=1, each rising edge on `evt_i` advances the counter once. If `evt_i` rises before clock edge k, `cnt_en_o` is high between edges k+1 and k+2, and the counter changes at edge k+2. Levels held for at least one clock cycle are seen.
- R5: In external mode, falling edges and steady levels do not count. A level that is already high when counting starts is not an edge.
- R6: In external mode the internal divider is held cleared and drives no count pulse, whatever the select code. After a return to internal mode, the first pulse again comes after a full 2^n cycles.
- R7: `src_sel_i` and `div_sel_i` are captured on each clock edge at which `run_i` is low. Changes made while `run_i` is high are ignored until the next halted edge.
- R8: While `run_i` is low, `cnt_en_o` stays low and the counter holds its value. Event edges during the halt are dropped. On restart the divider begins a fresh period, so no pulse comes before 2^n running cycles.
- R9: Each count-enable pulse adds exactly 1, and the counter wraps from 0xFFFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| src_sel_i | input | 1 | Count source: 0 internal divider, 1 external events |
| div_sel_i | input | 4 | Divider select code n (period 2^n); 15 reserved |
| run_i | input | 1 | 1 counts, 0 halts and opens configuration capture |
| evt_i | input | 1 | Asynchronous external event input |
| cnt_en_o | output | 1 | Count-enable strobe that advances the counter |
| cnt_o | output | 16 | Counter value |

## Verification
On every cycle, assertions check the following:
- the counter steps by exactly one on a strobe and holds otherwise;
- the strobe is silent while halted and for the reserved code;
- the divider stays cleared in external mode;
- the configuration is frozen while running;
- detected edges are never back to back.

Only the bench's scenarios can show the rest. These are the exact period and first-pulse position for every select code, the three-edge latency from the event pin, the rejection of levels and of edges seen during a halt, the wrap point, and the capture of configuration at reset and at halt.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } src_e;
endpackage

// File: rtl/tcs_cfg_hold.sv
module tcs_cfg_hold
  import tcs_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             run_i,
  input  logic             mode_i,
  input  logic [SEL_W-1:0] sel_i,
  output src_e             mode_o,
  output logic [SEL_W-1:0] sel_o
);
  src_e             mode_q;
  logic [SEL_W-1:0] sel_q;

  // Configuration only opens while counting is halted.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mode_q <= SRC_INT;
      sel_q  <= '0;
    end else if (!run_i) begin
      mode_q <= src_e'(mode_i);
      sel_q  <= sel_i;
    end
  end

  assign mode_o = mode_q;
  assign sel_o  = sel_q;

  assert_cfg_frozen_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(run_i) && !$past(rst_i)) |-> ($stable(mode_q) && $stable(sel_q)));
endmodule

// File: rtl/tcs_prescaler.sv
module tcs_prescaler #(
  parameter int DIV_W = 14,
  parameter int SEL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             active_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o,
  output logic [DIV_W-1:0] div_o
);
  localparam int NTAP = DIV_W + 1;
  localparam logic [SEL_W-1:0] SEL_RSV = {SEL_W{1'b1}};

  logic [DIV_W-1:0] div_q;
  logic [NTAP-1:0]  tap;
  logic             hit;

  // Chain is cleared whenever it is not in use, so each run starts a fresh period.
  always_ff @(posedge clk_i) begin
    if (rst_i || !active_i) div_q <= '0;
    else                    div_q <= div_q + DIV_W'(1);
  end

  assign tap[0] = 1'b1;
  for (genvar g = 1; g < NTAP; g++) begin : g_tap
    assign tap[g] = &div_q[g-1:0];
  end

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NTAP; i++) begin
      if (sel_i == SEL_W'(i)) hit = tap[i];
    end
  end

  assign tick_o = active_i && hit;
  assign div_o  = div_q;

  assert_reserved_quiet_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (sel_i == SEL_RSV) |-> !tick_o);
  assert_tap_spacing_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_o && sel_i != '0) |=> !tick_o);
endmodule

// File: rtl/tcs_edge_det.sv
module tcs_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] && !prev_q;

  assert_single_rise_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tcs_counter.sv
module tcs_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] value_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)      cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign value_o = cnt_q;

  assert_cnt_step_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    inc_i |=> (value_o == $past(value_o) + CNT_W'(1)));
  assert_cnt_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    !inc_i |=> $stable(value_o));
endmodule

// File: rtl/tcs_count_src.sv
module tcs_count_src
  import tcs_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DIV_W       = 14,
  parameter int SEL_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             src_sel_i,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic             run_i,
  input  logic             evt_i,
  output logic             cnt_en_o,
  output logic [CNT_W-1:0] cnt_o
);
  src_e             mode_q;
  logic [SEL_W-1:0] sel_q;
  logic             pre_active;
  logic             pre_tick;
  logic [DIV_W-1:0] pre_cnt;
  logic             evt_rise;
  logic             cnt_en;

  tcs_cfg_hold #(.SEL_W(SEL_W)) cfg_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .run_i  (run_i),
    .mode_i (src_sel_i),
    .sel_i  (div_sel_i),
    .mode_o (mode_q),
    .sel_o  (sel_q)
  );

  assign pre_active = run_i && (mode_q == SRC_INT);

  tcs_prescaler #(.DIV_W(DIV_W), .SEL_W(SEL_W)) pre_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .active_i (pre_active),
    .sel_i    (sel_q),
    .tick_o   (pre_tick),
    .div_o    (pre_cnt)
  );

  tcs_edge_det #(.STAGES(SYNC_STAGES)) edge_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .async_i (evt_i),
    .rise_o  (evt_rise)
  );

  assign cnt_en = run_i && ((mode_q == SRC_EXT) ? evt_rise : pre_tick);

  tcs_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .inc_i   (cnt_en),
    .value_o (cnt_o)
  );

  assign cnt_en_o = cnt_en;

  assert_halt_quiet_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    !run_i |-> !cnt_en_o);
  assert_pre_idle_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_q == SRC_EXT) |=> (pre_cnt == '0));
endmodule

// File: tb/tcs_count_src_tb.sv
module tcs_count_src_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        src = 1'b0;
  logic [3:0]  div = 4'd0;
  logic        run = 1'b0;
  logic        evt = 1'b0;
  logic        cnt_en;
  logic [15:0] cnt;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  localparam int WD_LIMIT = 190000;

  always #2 clk = ~clk;

  tcs_count_src dut_i (
    .clk_i     (clk),
    .rst_i     (rst),
    .src_sel_i (src),
    .div_sel_i (div),
    .run_i     (run),
    .evt_i     (evt),
    .cnt_en_o  (cnt_en),
    .cnt_o     (cnt)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_LIMIT && !done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    run = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic config_set(input logic m, input logic [3:0] d);
    run = 1'b0;
    src = m;
    div = d;
    @(negedge clk);
  endtask

  task automatic run_for(input int k);
    run = 1'b1;
    repeat (k) @(negedge clk);
  endtask

  task automatic halt_for(input int k);
    run = 1'b0;
    repeat (k) @(negedge clk);
  endtask

  task automatic pulse(input int hi, input int lo);
    evt = 1'b1;
    repeat (hi) @(negedge clk);
    evt = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    // R1: reset state, configuration taken from reset not from inputs
    src = 1'b1;
    div = 4'd5;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 counter after reset", int'(cnt), 0);
    chk("R1 strobe after reset", int'(cnt_en), 0);
    rst = 1'b0;
    run = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset config is internal divide-by-1", int'(cnt), 3);

    // R2: sweep every legal select code
    for (int n = 0; n <= 14; n++) begin
      int c;
      c = (2 << n) + 1;
      do_reset();
      config_set(1'b0, 4'(n));
      run_for((1 << n) - 1);
      chk($sformatf("R2 n=%0d before first pulse", n), int'(cnt), 0);
      run_for(c - (1 << n) + 1);
      chk($sformatf("R2 n=%0d after %0d cycles", n, c), int'(cnt), c >> n);
      halt_for(1);
    end

    // R3: reserved code
    do_reset();
    config_set(1'b0, 4'hF);
    run_for(200);
    chk("R3 reserved code silent", int'(cnt), 0);
    halt_for(1);

    // R7: configuration writes while running are ignored
    do_reset();
    config_set(1'b0, 4'd0);
    run_for(4);
    src = 1'b1;
    div = 4'd3;
    run_for(4);
    chk("R7 running change ignored", int'(cnt), 8);
    halt_for(1);
    config_set(1'b0, 4'd3);
    run_for(8);
    chk("R7 halted capture takes effect", int'(cnt), 9);
    halt_for(1);

    // R8: halt holds and restart begins a fresh period
    do_reset();
    config_set(1'b0, 4'd2);
    run_for(6);
    chk("R8 before halt", int'(cnt), 1);
    halt_for(10);
    chk("R8 held while halted", int'(cnt), 1);
    chk("R8 strobe low while halted", int'(cnt_en), 0);
    run_for(3);
    chk("R8 no early pulse on restart", int'(cnt), 1);
    run_for(1);
    chk("R8 pulse after full period", int'(cnt), 2);
    halt_for(1);

    // R9: wrap
    do_reset();
    config_set(1'b0, 4'd0);
    run_for(65535);
    chk("R9 top value", int'(cnt), 65535);
    run_for(1);
    chk("R9 wrap to zero", int'(cnt), 0);
    run_for(1);
    chk("R9 step after wrap", int'(cnt), 1);
    halt_for(1);

    // R4/R5/R6: external event counting
    do_reset();
    evt = 1'b0;
    config_set(1'b1, 4'd0);
    run_for(20);
    chk("R6 divider drives nothing in external mode", int'(cnt), 0);
    evt = 1'b1;
    @(negedge clk);
    chk("R4 latency edge 1", int'(cnt), 0);
    @(negedge clk);
    chk("R4 latency edge 2", int'(cnt), 0);
    chk("R4 strobe before third edge", int'(cnt_en), 1);
    @(negedge clk);
    chk("R4 count at third edge", int'(cnt), 1);
    repeat (10) @(negedge clk);
    chk("R5 steady high not counted", int'(cnt), 1);
    evt = 1'b0;
    repeat (5) @(negedge clk);
    chk("R5 falling edge not counted", int'(cnt), 1);
    for (int p = 1; p <= 6; p++) pulse(p, p);
    repeat (4) @(negedge clk);
    chk("R4 pulses of several widths", int'(cnt), 7);

    // R8/R5: edges during halt dropped, high level at restart not an edge
    halt_for(1);
    for (int q = 0; q < 3; q++) pulse(2, 2);
    repeat (3) @(negedge clk);
    chk("R8 halted edges dropped", int'(cnt), 7);
    evt = 1'b1;
    repeat (4) @(negedge clk);
    run_for(6);
    chk("R5 level high at restart not counted", int'(cnt), 7);
    evt = 1'b0;
    repeat (3) @(negedge clk);
    evt = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4 edge after restart counted", int'(cnt), 8);
    evt = 1'b0;

    // R6: back to internal mode, full period before first pulse
    halt_for(1);
    config_set(1'b0, 4'd4);
    run_for(15);
    chk("R6 no early pulse after external mode", int'(cnt), 8);
    run_for(1);
    chk("R6 first pulse after full period", int'(cnt), 9);
    halt_for(2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule